// File: doc/BRIEF.md
# CPU Clock Rate Change Sequencer

This block carries out a change of the CPU clock rate in hardware. A requester presents a rate in kHz. A rounding stage maps that rate onto an entry of a small built-in rate table. Each entry holds four things: a CPU rate, the PLL rate that feeds it, and one word for each of the two divider registers.

The sequencer then drives the clock register unit through a fixed series of steps, and polls that unit's status fields between them. The steps are: setting or clearing the alternate-source select, writing the two divider words, and asking the PLL for a new rate. The order of the steps depends on whether the new rate is below or above the present one. Whichever way the rate moves, the CPU runs from the alternate clock while the PLL is being changed.

The requester sees `busy` for the whole operation. A one-cycle `done` marks success. An error flag marks a status wait that never completed.

Top module: `cpu_rate_seq`

## Requirements
- R1: The rate table is sorted by rate, highest first. It holds these entries (CPU rate / PLL rate / divider 0 word / divider 1 word):
  - entry 0: 1200000 / 1200000 / 0xD0000000 / 0x00000100
  - entry 1: 800000 / 800000 / 0xD0000001 / 0x00000101
  - entry 2: 600000 / 1200000 / 0xD0000002 / 0x00000102
  - entry 3: 300000 / 600000 / 0xD0000003 / 0x00000103

  A request selects the first entry whose rate is less than or equal to the requested rate. If no entry qualifies, the request selects the last entry.
- R2: If the selected rate equals the current rate, `done` pulses two cycles after the request is accepted. No select change, divider write or PLL request takes place.
- R3: On a decrease the order of steps is: set the alternate select, PLL request, divider 0 write, divider 1 write, clear the alternate select. The PLL request carries the entry's CPU rate.
- R4: On an increase the order of steps is: divider 0 write, divider 1 write, set the alternate select, PLL request, clear the alternate select. The PLL request carries the entry's PLL rate.
- R5: Divider 0 is written with the entry's divider 0 word, and divider 1 with its divider 1 word. Divider 1 is written only after the divider 0 status reads zero. The next step after divider 1 waits until the divider 1 status reads zero.
- R6: A PLL request is raised only while the alternate select is set and after the mux status has read 2 (parked on the alternate clock). The request is held until the acknowledge.
- R7: Every change ends by clearing the alternate select and waiting for mux status 1. After that, `done` pulses for one cycle and `curRate` takes the new rate. In the next cycle `busy` is low.
- R8: A status or acknowledge wait that lasts `TIMEOUT_CYC` cycles aborts the change. On an abort the sequencer sets `err`, clears the alternate select, returns to idle without `done` and leaves `curRate` unchanged. `err` clears when the next request is accepted.
- R9: A request presented while `busy` is high is ignored, both at that moment and afterwards.
- R10: After reset, `busy`, `done`, `err`, `altSel`, `pllReq` and both divider write strobes are low, and `curRate` is 600000 (entry 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, taken only when idle |
| reqRate | input | RATE_W | Requested CPU rate in kHz |
| muxStat | input | MUX_W | Mux status from register unit (1 main, 2 alternate) |
| divStat0 | input | STAT_W | Divider 0 status, zero when settled |
| divStat1 | input | STAT_W | Divider 1 status, zero when settled |
| pllAck | input | 1 | PLL reprogram acknowledge |
| altSel | output | 1 | Alternate-source select |
| divWr0 | output | 1 | Divider 0 write strobe |
| divWr1 | output | 1 | Divider 1 write strobe |
| divData | output | DIV_W | Divider word for the active write strobe |
| pllReq | output | 1 | PLL reprogram request |
| pllRate | output | RATE_W | Rate for the PLL request, in kHz |
| busy | output | 1 | Change in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last change aborted on timeout |
| curRate | output | RATE_W | Current CPU rate in kHz |

## Verification
Several properties are checked on every cycle. A PLL request never appears unless the alternate select is set. Divider writes fall on the correct side of parking for the direction of the change. `done` only occurs with the select released, and is followed by idle. `err` is never seen together with `busy`. The target entry and the current rate stay frozen except at accept and commit.

Other behaviours need the bench's scenarios, driven against its models of the register unit and the PLL. These are:
- the exact order of steps for rising, falling and unchanged rates;
- the PLL and divider values carried by each step;
- the rounding of out-of-table requests;
- the abort on a stalled PLL;
- the rejection of a request made mid-change.

// File: rtl/cpu_rate_pkg.sv
package cpu_rate_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_DECIDE, S_ALT_ON, S_WAIT_ALT, S_PLL, S_DIV0, S_WAIT0,
    S_DIV1, S_WAIT1, S_ALT_OFF, S_WAIT_MAIN, S_FINISH
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latchReq;
    logic setAlt;
    logic clrAlt;
    logic wrDiv0;
    logic wrDiv1;
    logic commit;
  } seqStrobe_t;

  localparam logic [2:0] MUX_MAIN   = 3'd1;
  localparam logic [2:0] MUX_PARKED = 3'd2;

  // CPU rate of an entry in kHz, highest first
  function automatic logic [31:0] entryFreq(input int idx);
    case (idx)
      0: return 32'd1200000;
      1: return 32'd800000;
      2: return 32'd600000;
      3: return 32'd300000;
      default: return 32'(300000 / (idx - 2));
    endcase
  endfunction

  // PLL rate that feeds an entry in kHz
  function automatic logic [31:0] parentFreq(input int idx);
    case (idx)
      0: return 32'd1200000;
      1: return 32'd800000;
      2: return 32'd1200000;
      default: return 32'd600000;
    endcase
  endfunction

  function automatic logic [31:0] div0Word(input int idx);
    return 32'hD000_0000 | 32'(idx);
  endfunction

  function automatic logic [31:0] div1Word(input int idx);
    return 32'h0000_0100 | 32'(idx);
  endfunction

endpackage

// File: rtl/cpu_rate_dp.sv
module cpu_rate_dp
  import cpu_rate_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int RATE_W      = 24,
  parameter int DIV_W       = 32,
  parameter int RESET_IDX   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        stb,
  input  logic              busy,
  input  logic [RATE_W-1:0] reqRate,
  output logic              rateUp,
  output logic              rateDown,
  output logic              altSel,
  output logic [DIV_W-1:0]  divData,
  output logic [RATE_W-1:0] pllRate,
  output logic [RATE_W-1:0] curRate
);

  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

  logic [RATE_W-1:0] freqTbl   [NUM_ENTRIES];
  logic [RATE_W-1:0] parentTbl [NUM_ENTRIES];
  logic [DIV_W-1:0]  div0Tbl   [NUM_ENTRIES];
  logic [DIV_W-1:0]  div1Tbl   [NUM_ENTRIES];

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_tbl
    assign freqTbl[g]   = RATE_W'(entryFreq(g));
    assign parentTbl[g] = RATE_W'(parentFreq(g));
    assign div0Tbl[g]   = DIV_W'(div0Word(g));
    assign div1Tbl[g]   = DIV_W'(div1Word(g));
  end

  logic [IDX_W-1:0] roundIdx, tgtIdx, curIdx;

  // first entry not above the request wins; last entry if none
  always_comb begin
    roundIdx = IDX_W'(NUM_ENTRIES - 1);
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (reqRate >= freqTbl[i]) roundIdx = IDX_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tgtIdx <= IDX_W'(RESET_IDX);
      curIdx <= IDX_W'(RESET_IDX);
      altSel <= 1'b0;
    end else begin
      if (stb.latchReq) tgtIdx <= roundIdx;
      if (stb.commit)   curIdx <= tgtIdx;
      if (stb.setAlt)      altSel <= 1'b1;
      else if (stb.clrAlt) altSel <= 1'b0;
    end
  end

  assign rateUp   = freqTbl[tgtIdx] > freqTbl[curIdx];
  assign rateDown = freqTbl[tgtIdx] < freqTbl[curIdx];
  assign pllRate  = rateDown ? freqTbl[tgtIdx] : parentTbl[tgtIdx];
  assign divData  = stb.wrDiv1 ? div1Tbl[tgtIdx] : div0Tbl[tgtIdx];
  assign curRate  = freqTbl[curIdx];

  // R9
  tgt_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(tgtIdx));

  // R7
  cur_rate_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.commit |=> $stable(curRate));

  // R3 R4
  div_park_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrDiv0 || stb.wrDiv1) |-> (rateDown ? altSel : !altSel));

endmodule

// File: rtl/cpu_rate_ctrl.sv
module cpu_rate_ctrl
  import cpu_rate_pkg::*;
#(
  parameter int MUX_W       = 3,
  parameter int STAT_W      = 4,
  parameter int TIMEOUT_CYC = 1024
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              rateUp,
  input  logic              rateDown,
  input  logic [MUX_W-1:0]  muxStat,
  input  logic [STAT_W-1:0] divStat0,
  input  logic [STAT_W-1:0] divStat1,
  input  logic              pllAck,
  input  logic              altSel,
  output seqStrobe_t        stb,
  output logic              pllReq,
  output logic              busy,
  output logic              done,
  output logic              err
);

  localparam int TMO_W = $clog2(TIMEOUT_CYC + 1);

  seqState_t        state, nextState;
  logic [TMO_W-1:0] tmoCnt;
  logic             waitState, condMet, expire;

  always_comb begin
    nextState = state;
    stb       = '0;
    pllReq    = 1'b0;
    condMet   = 1'b0;
    waitState = state inside {S_WAIT_ALT, S_PLL, S_WAIT0, S_WAIT1, S_WAIT_MAIN};
    case (state)
      S_IDLE: if (reqValid) begin
        stb.latchReq = 1'b1;
        nextState    = S_DECIDE;
      end
      S_DECIDE: begin
        if (rateDown)    nextState = S_ALT_ON;
        else if (rateUp) nextState = S_DIV0;
        else             nextState = S_FINISH;
      end
      S_ALT_ON: begin
        stb.setAlt = 1'b1;
        nextState  = S_WAIT_ALT;
      end
      S_WAIT_ALT: begin
        condMet = (muxStat == MUX_W'(MUX_PARKED));
        if (condMet) nextState = S_PLL;
      end
      S_PLL: begin
        pllReq  = 1'b1;
        condMet = pllAck;
        if (condMet) nextState = rateDown ? S_DIV0 : S_ALT_OFF;
      end
      S_DIV0: begin
        stb.wrDiv0 = 1'b1;
        nextState  = S_WAIT0;
      end
      S_WAIT0: begin
        condMet = (divStat0 == '0);
        if (condMet) nextState = S_DIV1;
      end
      S_DIV1: begin
        stb.wrDiv1 = 1'b1;
        nextState  = S_WAIT1;
      end
      S_WAIT1: begin
        condMet = (divStat1 == '0);
        if (condMet) nextState = rateDown ? S_ALT_OFF : S_ALT_ON;
      end
      S_ALT_OFF: begin
        stb.clrAlt = 1'b1;
        nextState  = S_WAIT_MAIN;
      end
      S_WAIT_MAIN: begin
        condMet = (muxStat == MUX_W'(MUX_MAIN));
        if (condMet) nextState = S_FINISH;
      end
      S_FINISH: begin
        stb.commit = 1'b1;
        nextState  = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
    expire = waitState && !condMet && (tmoCnt == TMO_W'(TIMEOUT_CYC - 1));
    if (expire) begin
      nextState  = S_IDLE;
      stb.clrAlt = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      tmoCnt <= '0;
      err    <= 1'b0;
    end else begin
      state <= nextState;
      if (nextState != state || !waitState) tmoCnt <= '0;
      else                                  tmoCnt <= tmoCnt + TMO_W'(1);
      if (stb.latchReq) err <= 1'b0;
      else if (expire)  err <= 1'b1;
    end
  end

  assign busy = (state != S_IDLE);
  assign done = (state == S_FINISH);

  // R6
  pll_parked_chk: assert property (@(posedge clk) disable iff (!rstN)
    pllReq |-> altSel);

  // R8
  err_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    err |-> !busy);

  // R7
  done_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !altSel);

  // R7
  done_then_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);

endmodule

// File: rtl/cpu_rate_seq.sv
module cpu_rate_seq
  import cpu_rate_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int RATE_W      = 24,
  parameter int DIV_W       = 32,
  parameter int MUX_W       = 3,
  parameter int STAT_W      = 4,
  parameter int TIMEOUT_CYC = 1024,
  parameter int RESET_IDX   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [RATE_W-1:0] reqRate,
  input  logic [MUX_W-1:0]  muxStat,
  input  logic [STAT_W-1:0] divStat0,
  input  logic [STAT_W-1:0] divStat1,
  input  logic              pllAck,
  output logic              altSel,
  output logic              divWr0,
  output logic              divWr1,
  output logic [DIV_W-1:0]  divData,
  output logic              pllReq,
  output logic [RATE_W-1:0] pllRate,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [RATE_W-1:0] curRate
);

  seqStrobe_t stb;
  logic       rateUp, rateDown;

  cpu_rate_ctrl #(
    .MUX_W(MUX_W), .STAT_W(STAT_W), .TIMEOUT_CYC(TIMEOUT_CYC)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .rateUp(rateUp), .rateDown(rateDown), .muxStat(muxStat),
    .divStat0(divStat0), .divStat1(divStat1), .pllAck(pllAck),
    .altSel(altSel), .stb(stb), .pllReq(pllReq),
    .busy(busy), .done(done), .err(err)
  );

  cpu_rate_dp #(
    .NUM_ENTRIES(NUM_ENTRIES), .RATE_W(RATE_W), .DIV_W(DIV_W),
    .RESET_IDX(RESET_IDX)
  ) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .busy(busy), .reqRate(reqRate),
    .rateUp(rateUp), .rateDown(rateDown), .altSel(altSel),
    .divData(divData), .pllRate(pllRate), .curRate(curRate)
  );

  assign divWr0 = stb.wrDiv0;
  assign divWr1 = stb.wrDiv1;

endmodule

// File: tb/test_cpu_rate_seq.sv
module test_cpu_rate_seq;
  localparam int CLK_PERIOD = 10;
  localparam int RW  = 24;
  localparam int DW  = 32;
  localparam int SW  = 4;
  localparam int TMO = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [RW-1:0] reqRate = '0;
  logic [2:0] muxStat;
  logic [SW-1:0] divStat0, divStat1;
  logic pllAck;
  logic altSel, divWr0, divWr1, pllReq, busy, done, err;
  logic [DW-1:0] divData;
  logic [RW-1:0] pllRate, curRate;

  int testCnt = 0;
  int failCnt = 0;
  bit finished = 0;
  bit pllStall = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpu_rate_seq #(.TIMEOUT_CYC(TMO)) i_cpu_rate_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqRate(reqRate),
    .muxStat(muxStat), .divStat0(divStat0), .divStat1(divStat1),
    .pllAck(pllAck), .altSel(altSel), .divWr0(divWr0), .divWr1(divWr1),
    .divData(divData), .pllReq(pllReq), .pllRate(pllRate), .busy(busy),
    .done(done), .err(err), .curRate(curRate)
  );

  // expected table, from R1
  function automatic logic [31:0] bFreq(input int i);
    case (i) 0: return 1200000; 1: return 800000; 2: return 600000; default: return 300000; endcase
  endfunction
  function automatic logic [31:0] bParent(input int i);
    case (i) 0: return 1200000; 1: return 800000; 2: return 1200000; default: return 600000; endcase
  endfunction
  function automatic logic [31:0] bDiv0(input int i); return 32'hD000_0000 + 32'(i); endfunction
  function automatic logic [31:0] bDiv1(input int i); return 32'h0000_0100 + 32'(i); endfunction

  // register unit model: mux status
  int muxCnt;
  logic lastAlt;
  always @(posedge clk) begin
    if (!rstN) begin
      muxStat <= 3'd1; muxCnt <= 0; lastAlt <= 1'b0;
    end else begin
      lastAlt <= altSel;
      if (altSel != lastAlt) begin
        muxCnt <= 2; muxStat <= 3'd4;
      end else if (muxCnt > 0) begin
        muxCnt <= muxCnt - 1;
        if (muxCnt == 1) muxStat <= altSel ? 3'd2 : 3'd1;
      end
    end
  end

  // register unit model: divider status
  int d0Cnt, d1Cnt;
  always @(posedge clk) begin
    if (!rstN) begin
      d0Cnt <= 0; d1Cnt <= 0;
    end else begin
      if (divWr0) d0Cnt <= 3; else if (d0Cnt > 0) d0Cnt <= d0Cnt - 1;
      if (divWr1) d1Cnt <= 4; else if (d1Cnt > 0) d1Cnt <= d1Cnt - 1;
    end
  end
  assign divStat0 = (d0Cnt != 0 || divWr0) ? 4'h1 : 4'h0;
  assign divStat1 = (d1Cnt != 0 || divWr1) ? 4'h2 : 4'h0;

  // PLL model
  int pCnt;
  always @(posedge clk) begin
    if (!rstN) begin
      pllAck <= 1'b0; pCnt <= 0;
    end else if (pllAck) begin
      pllAck <= 1'b0;
    end else if (pllReq && !pllStall) begin
      if (pCnt == 2) begin pllAck <= 1'b1; pCnt <= 0; end
      else pCnt <= pCnt + 1;
    end else begin
      pCnt <= 0;
    end
  end

  // event log: 1 alt on, 2 pll, 3 div0, 4 div1, 5 alt off
  int evKind [128];
  logic [31:0] evVal [128];
  logic [31:0] evAux [128];
  int evCnt = 0;
  logic prevAlt = 1'b0, prevPll = 1'b0;
  always @(posedge clk) begin
    if (rstN && evCnt < 124) begin
      if (altSel && !prevAlt) begin evKind[evCnt] = 1; evVal[evCnt] = 0; evAux[evCnt] = 0; evCnt++; end
      if (!altSel && prevAlt) begin evKind[evCnt] = 5; evVal[evCnt] = 0; evAux[evCnt] = 0; evCnt++; end
      if (pllReq && !prevPll) begin evKind[evCnt] = 2; evVal[evCnt] = 32'(pllRate); evAux[evCnt] = 32'(muxStat); evCnt++; end
      if (divWr0) begin evKind[evCnt] = 3; evVal[evCnt] = divData; evAux[evCnt] = 0; evCnt++; end
      if (divWr1) begin evKind[evCnt] = 4; evVal[evCnt] = divData; evAux[evCnt] = 32'(divStat0); evCnt++; end
    end
    prevAlt = altSel;
    prevPll = pllReq;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic issueReq(input logic [31:0] r);
    @(negedge clk);
    reqValid = 1'b1;
    reqRate  = RW'(r);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic waitDone(output int cyc);
    cyc = 1;
    while (!done && cyc < 3000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  // compare a finished change against the expected step order and values
  task automatic checkSeq(input int base, input int idx, input int prevIdx);
    int upOrd [5];
    int dnOrd [5];
    bit down, up;
    int n;
    upOrd = '{3, 4, 1, 2, 5};
    dnOrd = '{1, 2, 3, 4, 5};
    down = bFreq(idx) < bFreq(prevIdx);
    up   = bFreq(idx) > bFreq(prevIdx);
    n = evCnt - base;
    if (!down && !up) begin
      check(n == 0, "R2 no steps on equal rate", n, 0);
      return;
    end
    check(n == 5, down ? "R3 step count" : "R4 step count", n, 5);
    if (n != 5) return;
    for (int k = 0; k < 5; k++) begin
      int e;
      e = down ? dnOrd[k] : upOrd[k];
      check(evKind[base+k] == e, down ? "R3 step order" : "R4 step order", evKind[base+k], e);
      if (evKind[base+k] == 2) begin
        check(evVal[base+k] == (down ? bFreq(idx) : bParent(idx)),
              down ? "R3 pll rate" : "R4 pll rate", evVal[base+k],
              down ? bFreq(idx) : bParent(idx));
        check(evAux[base+k] == 2, "R6 parked before pll", evAux[base+k], 2);
      end
      if (evKind[base+k] == 3)
        check(evVal[base+k] == bDiv0(idx), "R5 div0 word", evVal[base+k], bDiv0(idx));
      if (evKind[base+k] == 4) begin
        check(evVal[base+k] == bDiv1(idx), "R5 div1 word", evVal[base+k], bDiv1(idx));
        check(evAux[base+k] == 0, "R5 div0 settled first", evAux[base+k], 0);
      end
    end
  endtask

  localparam logic [31:0] V_REQ [6] = '{32'd1300000, 32'd850000, 32'd800000, 32'd100000, 32'd650000, 32'd1200000};
  localparam int          V_IDX [6] = '{0, 1, 1, 3, 2, 0};

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failCnt++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  initial begin
    int cur;
    int cyc;
    int base;
    bit sawDone;
    cur = 2;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10
    check(busy == 0, "R10 busy", busy, 0);
    check(done == 0, "R10 done", done, 0);
    check(err == 0, "R10 err", err, 0);
    check(altSel == 0, "R10 altSel", altSel, 0);
    check(pllReq == 0, "R10 pllReq", pllReq, 0);
    check(divWr0 == 0 && divWr1 == 0, "R10 div strobes", {divWr0, divWr1}, 0);
    check(32'(curRate) == 600000, "R10 curRate", curRate, 600000);

    for (int v = 0; v < 6; v++) begin
      base = evCnt;
      issueReq(V_REQ[v]);
      waitDone(cyc);
      check(done == 1, "R7 done pulse", done, 1);
      if (bFreq(V_IDX[v]) == bFreq(cur))
        check(cyc == 2, "R2 quick done", cyc, 2);
      @(negedge clk);
      check(done == 0, "R7 done one cycle", done, 0);
      check(busy == 0, "R7 idle after done", busy, 0);
      check(32'(curRate) == bFreq(V_IDX[v]), "R1 rounded rate", curRate, bFreq(V_IDX[v]));
      checkSeq(base, V_IDX[v], cur);
      cur = V_IDX[v];
    end

    // R9: request during a change is ignored
    base = evCnt;
    issueReq(300000);
    repeat (3) @(negedge clk);
    check(busy == 1, "R9 busy during change", busy, 1);
    reqValid = 1'b1; reqRate = RW'(32'd1300000);
    @(negedge clk);
    reqValid = 1'b0;
    waitDone(cyc);
    @(negedge clk);
    check(32'(curRate) == 300000, "R9 first request wins", curRate, 300000);
    checkSeq(base, 3, cur);
    cur = 3;
    base = evCnt;
    repeat (10) @(negedge clk);
    check(busy == 0, "R9 no late start", busy, 0);
    check(evCnt == base, "R9 no late steps", evCnt - base, 0);

    // R8: stalled PLL aborts
    pllStall = 1;
    issueReq(1300000);
    sawDone = 0;
    cyc = 0;
    while (busy && cyc < 3000) begin
      @(negedge clk);
      if (done) sawDone = 1;
      cyc++;
    end
    check(err == 1, "R8 err raised", err, 1);
    check(sawDone == 0, "R8 no done", sawDone, 0);
    check(32'(curRate) == 300000, "R8 rate kept", curRate, 300000);
    check(altSel == 0, "R8 select released", altSel, 0);
    check(pllReq == 0, "R8 pll request dropped", pllReq, 0);
    repeat (10) @(negedge clk);
    pllStall = 0;
    base = evCnt;
    issueReq(300000);
    waitDone(cyc);
    check(done == 1 && cyc == 2, "R2 equal after abort", cyc, 2);
    check(err == 0, "R8 err cleared on accept", err, 0);
    check(evCnt == base, "R2 no steps", evCnt - base, 0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule